// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block executes one data-processing operation per cycle for a 32-bit integer pipeline. It takes the first operand, a second operand that an upstream shifter has already prepared together with that shifter's carry-out, a 4-bit operation code, a flag-update request and a 4-bit condition code. The condition code is tested against a four-bit flag store (negative, zero, carry, overflow) held inside the block. If the test passes, the block marks the operation as executed, computes the result and says whether the destination register should be written and whether the flag store takes new values.

The result, the execute indication and both write enables are combinational from the inputs and the stored flags. The flag store updates at the next rising clock edge. Fetching operands, shifting and writing registers back all happen outside the block. An issue strobe marks the cycles that carry a real operation.

Top module: `cdp_alu`

## Requirements
- R1: Logical operation codes give result = A&B (0000, and 1000 as a test), A^B (0001, and 1001 as a test), A|B (1100), B (1101), A&~B (1110) and ~B (1111).
- R2: Arithmetic codes give A-B (0010, and 1010 as a compare), B-A (0011) and A+B (0100, and 1011 as a compare), all modulo 2^DATA_W.
- R3: The carry-using codes read the stored C flag: 0101 gives A+B+C, 0110 gives A-B+C-1 and 0111 gives B-A+C-1.
- R4: Codes 1000 to 1011 never assert wr_en_o. They assert flag_we_o whenever they execute, whatever the value of set_flags_i.
- R5: exec_o = issue_i AND the condition passes on the stored flags. Conditions: 0000 Z, 0001 !Z, 0010 C, 0011 !C, 0100 N, 0101 !N, 0110 V, 0111 !V, 1000 C&!Z, 1001 !C|Z, 1010 N==V, 1011 N!=V, 1100 !Z&(N==V), 1101 Z|(N!=V), 1110 always.
- R6: Condition 1111 never executes: exec_o, wr_en_o and flag_we_o all stay low.
- R7: When exec_o is low, wr_en_o and flag_we_o are low and flags_o keeps its value across the next clock edge.
- R8: flags_o is {N,Z,C,V} on bits 3..0. After an update, N is the result's top bit and Z is set exactly when the result is zero.
- R9: After an arithmetic update, C is the adder carry-out (not-borrow for subtractions) and V is signed overflow. After a logical update, C takes shift_carry_i and V keeps its value.
- R10: A non-test code that executes with set_flags_i low writes the destination (wr_en_o high) and leaves flags_o unchanged.
- R11: Reset clears flags_o to 0000. A cycle with issue_i low writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An operation is presented this cycle |
| cond_i | input | 4 | Condition code |
| opcode_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Flag update requested |
| opnd_a_i | input | DATA_W | First operand |
| opnd_b_i | input | DATA_W | Prepared second operand |
| shift_carry_i | input | 1 | Carry-out of the operand shifter |
| result_o | output | DATA_W | Operation result |
| exec_o | output | 1 | Condition passed and operation issued |
| wr_en_o | output | 1 | Destination write enable |
| flag_we_o | output | 1 | Flag store update enable |
| flags_o | output | 4 | Stored flags {N,Z,C,V} |

## Verification
The assertions check on every cycle the rules that tie the control outputs together: condition 1111 is suppressed, test codes never write a destination and always update flags when they execute, the always condition executes, and flags hold when nothing updates them. They also check that stored N and Z follow the previous result, and that a logical update takes the shifter carry and keeps V. Only the bench's sweep shows that the arithmetic values, the carries and overflows of the six add/subtract forms, and each condition's decode are correct. For this the bench runs an arithmetic reference over boundary operands, with the stored carry changing as the sweep goes.

// File: rtl/cdp_alu_pkg.sv
package cdp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'h0, OP_EOR = 4'h1, OP_SUB = 4'h2, OP_RSB = 4'h3,
    OP_ADD = 4'h4, OP_ADC = 4'h5, OP_SBC = 4'h6, OP_RSC = 4'h7,
    OP_TST = 4'h8, OP_TEQ = 4'h9, OP_CMP = 4'hA, OP_CMN = 4'hB,
    OP_ORR = 4'hC, OP_MOV = 4'hD, OP_BIC = 4'hE, OP_MVN = 4'hF
  } op_e;

  typedef enum logic [3:0] {
    CC_EQ = 4'h0, CC_NE = 4'h1, CC_CS = 4'h2, CC_CC = 4'h3,
    CC_MI = 4'h4, CC_PL = 4'h5, CC_VS = 4'h6, CC_VC = 4'h7,
    CC_HI = 4'h8, CC_LS = 4'h9, CC_GE = 4'hA, CC_LT = 4'hB,
    CC_GT = 4'hC, CC_LE = 4'hD, CC_AL = 4'hE, CC_NV = 4'hF
  } cond_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  localparam flags_t FLAGS_RST = '0;

  // test/compare codes occupy 10xx
  function automatic logic is_test_op(input op_e op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic is_arith_op(input op_e op);
    return (op inside {OP_SUB, OP_RSB, OP_ADD, OP_ADC,
                       OP_SBC, OP_RSC, OP_CMP, OP_CMN});
  endfunction

endpackage

// File: rtl/cdp_cond_eval.sv
module cdp_cond_eval
  import cdp_alu_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);

  logic n_eq_v;
  assign n_eq_v = (flags_i.n == flags_i.v);

  always_comb begin
    unique case (cond_i)
      CC_EQ:   pass_o =  flags_i.z;
      CC_NE:   pass_o = !flags_i.z;
      CC_CS:   pass_o =  flags_i.c;
      CC_CC:   pass_o = !flags_i.c;
      CC_MI:   pass_o =  flags_i.n;
      CC_PL:   pass_o = !flags_i.n;
      CC_VS:   pass_o =  flags_i.v;
      CC_VC:   pass_o = !flags_i.v;
      CC_HI:   pass_o =  flags_i.c && !flags_i.z;
      CC_LS:   pass_o = !flags_i.c ||  flags_i.z;
      CC_GE:   pass_o =  n_eq_v;
      CC_LT:   pass_o = !n_eq_v;
      CC_GT:   pass_o = !flags_i.z && n_eq_v;
      CC_LE:   pass_o =  flags_i.z || !n_eq_v;
      CC_AL:   pass_o = 1'b1;
      default: pass_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cdp_alu_core.sv
module cdp_alu_core
  import cdp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              shift_carry_i,
  input  flags_t            flags_i,
  output logic [DATA_W-1:0] result_o,
  output flags_t            flags_o
);

  localparam int SUM_W = DATA_W + 1;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] add_x, add_y, logic_res;
  logic              add_ci, arith;
  logic [SUM_W-1:0]  sum;
  logic              ovf;

  // operand steering: subtraction is x + ~y + ci
  always_comb begin
    add_x  = a_i;
    add_y  = b_i;
    add_ci = 1'b0;
    unique case (op_i)
      OP_SUB, OP_CMP: begin add_y = ~b_i; add_ci = 1'b1; end
      OP_RSB:         begin add_x = b_i; add_y = ~a_i; add_ci = 1'b1; end
      OP_ADC:         add_ci = flags_i.c;
      OP_SBC:         begin add_y = ~b_i; add_ci = flags_i.c; end
      OP_RSC:         begin add_x = b_i; add_y = ~a_i; add_ci = flags_i.c; end
      default:        ;
    endcase
  end

  assign sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_ci};
  assign ovf = (add_x[MSB] == add_y[MSB]) && (sum[MSB] != add_x[MSB]);

  always_comb begin
    unique case (op_i)
      OP_AND, OP_TST: logic_res = a_i & b_i;
      OP_EOR, OP_TEQ: logic_res = a_i ^ b_i;
      OP_ORR:         logic_res = a_i | b_i;
      OP_MOV:         logic_res = b_i;
      OP_BIC:         logic_res = a_i & ~b_i;
      default:        logic_res = ~b_i;
    endcase
  end

  assign arith    = is_arith_op(op_i);
  assign result_o = arith ? sum[DATA_W-1:0] : logic_res;

  always_comb begin
    flags_o.n = result_o[MSB];
    flags_o.z = (result_o == '0);
    flags_o.c = arith ? sum[DATA_W] : shift_carry_i;
    flags_o.v = arith ? ovf : flags_i.v;
  end

endmodule

// File: rtl/cdp_flag_reg.sv
module cdp_flag_reg
  import cdp_alu_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   we_i,
  input  flags_t d_i,
  output flags_t q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= FLAGS_RST;
    else if (we_i) q_o <= d_i;
  end

endmodule

// File: rtl/cdp_alu.sv
module cdp_alu
  import cdp_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic [3:0]        cond_i,
  input  logic [3:0]        opcode_i,
  input  logic              set_flags_i,
  input  logic [DATA_W-1:0] opnd_a_i,
  input  logic [DATA_W-1:0] opnd_b_i,
  input  logic              shift_carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              exec_o,
  output logic              wr_en_o,
  output logic              flag_we_o,
  output logic [3:0]        flags_o
);

  op_e    op;
  flags_t flags_q, flags_d;
  logic   cond_ok, test_op;

  assign op      = op_e'(opcode_i);
  assign test_op = is_test_op(op);

  cdp_cond_eval u_cond (
    .cond_i  (cond_e'(cond_i)),
    .flags_i (flags_q),
    .pass_o  (cond_ok)
  );

  cdp_alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i          (op),
    .a_i           (opnd_a_i),
    .b_i           (opnd_b_i),
    .shift_carry_i (shift_carry_i),
    .flags_i       (flags_q),
    .result_o      (result_o),
    .flags_o       (flags_d)
  );

  assign exec_o    = issue_i && cond_ok;
  assign wr_en_o   = exec_o && !test_op;
  assign flag_we_o = exec_o && (set_flags_i || test_op);

  cdp_flag_reg u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (flag_we_o),
    .d_i    (flags_d),
    .q_o    (flags_q)
  );

  assign flags_o = flags_q;

endmodule

// File: rtl/cdp_alu_chk.sv
module cdp_alu_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_i,
  input logic [3:0]        cond_i,
  input logic [3:0]        opcode_i,
  input logic              shift_carry_i,
  input logic [DATA_W-1:0] result_o,
  input logic              exec_o,
  input logic              wr_en_o,
  input logic              flag_we_o,
  input logic [3:0]        flags_o
);

  logic test_op, logic_op;
  assign test_op  = (opcode_i[3:2] == 2'b10);
  assign logic_op = !(opcode_i inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'h7, 4'hA, 4'hB});

  assert_never_cond_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i == 4'hF) |-> (!exec_o && !wr_en_o && !flag_we_o));

  assert_test_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_op |-> !wr_en_o);

  assert_test_sets_flags_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_op && exec_o) |-> flag_we_o);

  assert_always_cond_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && cond_i == 4'hE) |-> exec_o);

  assert_skip_holds_flags_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |=> $stable(flags_o));

  assert_no_issue_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |-> (!exec_o && !wr_en_o && !flag_we_o));

  assert_nz_follow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_o |=> (flags_o[3] == $past(result_o[DATA_W-1]))
                  && (flags_o[2] == ($past(result_o) == '0)));

  assert_logic_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_we_o && logic_op) |=> (flags_o[1] == $past(shift_carry_i))
                                && (flags_o[0] == $past(flags_o[0])));

endmodule

bind cdp_alu cdp_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .issue_i       (issue_i),
  .cond_i        (cond_i),
  .opcode_i      (opcode_i),
  .shift_carry_i (shift_carry_i),
  .result_o      (result_o),
  .exec_o        (exec_o),
  .wr_en_o       (wr_en_o),
  .flag_we_o     (flag_we_o),
  .flags_o       (flags_o)
);

// File: tb/cdp_alu_tb_top.sv
module cdp_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 8;
  localparam int MASK = (1 << W) - 1;
  localparam int HALF = 1 << (W - 1);

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         issue_i = 1'b0;
  logic [3:0]   cond_i = 4'hE;
  logic [3:0]   opcode_i = 4'h0;
  logic         set_flags_i = 1'b0;
  logic [W-1:0] opnd_a_i = '0;
  logic [W-1:0] opnd_b_i = '0;
  logic         shift_carry_i = 1'b0;
  logic [W-1:0] result_o;
  logic         exec_o, wr_en_o, flag_we_o;
  logic [3:0]   flags_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 0;
  bit [3:0] mf  = 4'h0;  // model flags {N,Z,C,V}

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cdp_alu #(.DATA_W(W)) dut_i (.*);

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (op %0h cond %0h a %0h b %0h)",
               req, act, exp, opcode_i, cond_i, opnd_a_i, opnd_b_i);
    end
  endtask

  function automatic int sx(input int x);
    return (x >= HALF) ? x - (1 << W) : x;
  endfunction

  function automatic bit cond_ok(input int cc, input bit [3:0] f);
    bit n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      0: return z;          1: return !z;
      2: return c;          3: return !c;
      4: return n;          5: return !n;
      6: return v;          7: return !v;
      8: return c && !z;    9: return !c || z;
      10: return n == v;    11: return n != v;
      12: return !z && (n == v);
      13: return z || (n != v);
      14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // reference: r, and next flags
  task automatic model(input int op, input int a, input int b, input bit sc,
                       input bit [3:0] f, output int r, output bit [3:0] nf,
                       output bit arith);
    int s, sv, x, y, k;
    bit c, v;
    arith = 1'b1;
    c = sc;
    v = f[0];
    x = a; y = b; k = 0;
    case (op)
      2, 10: begin x = a; y = b; k = 0; end
      3:     begin x = b; y = a; k = 0; end
      6:     begin x = a; y = b; k = 1 - int'(f[1]); end
      7:     begin x = b; y = a; k = 1 - int'(f[1]); end
      4, 11: begin x = a; y = b; k = 0; end
      5:     begin x = a; y = b; k = int'(f[1]); end
      default: arith = 1'b0;
    endcase
    if (!arith) begin
      case (op)
        0, 8:  r = a & b;
        1, 9:  r = a ^ b;
        12:    r = a | b;
        13:    r = b;
        14:    r = a & ~b & MASK;
        default: r = ~b & MASK;
      endcase
    end else if (op inside {4, 5, 11}) begin
      s  = x + y + k;
      sv = sx(x) + sx(y) + k;
      r  = s & MASK;
      c  = (s > MASK);
      v  = (sv >= HALF) || (sv < -HALF);
    end else begin
      s  = x - y - k;
      sv = sx(x) - sx(y) - k;
      r  = s & MASK;
      c  = (s >= 0);
      v  = (sv >= HALF) || (sv < -HALF);
    end
    nf = {bit'(r >= HALF), bit'(r == 0), c, v};
  endtask

  task automatic step(input bit iss, input int cc, input int op, input bit sf,
                      input int a, input int b, input bit sc);
    int r;
    bit [3:0] nf;
    bit ar, ex, wr, fw, tst;
    @(negedge clk_i);
    issue_i = iss; cond_i = 4'(cc); opcode_i = 4'(op); set_flags_i = sf;
    opnd_a_i = W'(a); opnd_b_i = W'(b); shift_carry_i = sc;
    model(op, a, b, sc, mf, r, nf, ar);
    tst = (op >= 8 && op <= 11);
    ex  = iss && cond_ok(cc, mf);
    wr  = ex && !tst;
    fw  = ex && (sf || tst);
    #1;
    check(ar ? "R2/R3 result" : "R1 result", int'(result_o), r);
    check("R5/R6/R11 exec", int'(exec_o), int'(ex));
    check("R4/R6/R7/R10 wr_en", int'(wr_en_o), int'(wr));
    check("R4/R7/R10 flag_we", int'(flag_we_o), int'(fw));
    if (fw) mf = nf;
    @(posedge clk_i);
    #1;
    check("R7/R8/R9/R10 flags", int'(flags_o), int'(mf));
  endtask

  int vals[16] = '{0, 1, 2, 'h7F, 'h80, 'h81, 'hFE, 'hFF,
                   'h55, 'hAA, 'h0F, 'hF0, 'h3C, 'h40, 'hC0, 'h7E};

  initial begin
    int cnt;
    repeat (3) @(posedge clk_i);
    #1;
    check("R11 reset flags", int'(flags_o), 0);
    check("R11 idle exec", int'(exec_o), 0);
    rst_ni = 1'b1;

    // directed boundaries, AL condition
    step(1, 14, 4, 1, 'h7F, 'h01, 0);  // R9 overflow on add
    step(1, 14, 2, 1, 'h00, 'h01, 0);  // R9 borrow, C clear
    step(1, 14, 5, 1, 'hFF, 'h00, 0);  // R3 ADC with C clear
    step(1, 14, 10, 0, 'h10, 'h10, 1); // R4 compare sets Z with S low
    step(1, 0, 13, 0, 0, 'h33, 0);     // R5 EQ after Z set
    step(1, 15, 13, 1, 0, 'h33, 0);    // R6 never
    step(1, 1, 13, 1, 0, 'h00, 1);     // R7 NE fails, flags held

    // sweep: op x a x b x set_flags x shifter carry, condition rotated
    cnt = 0;
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 16; ia++)
        for (int ib = 0; ib < 16; ib++)
          for (int m = 0; m < 4; m++) begin
            step((cnt % 7) != 3, (cnt * 5 + (cnt >> 4)) % 16, op, m[0],
                 vals[ia], vals[(ib + op) % 16], m[1]);
            cnt++;
          end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 60000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule